// File: doc/BRIEF.md
# Serial-Readout Flag Register

This block holds the status flags produced by an arithmetic unit and shows them to the sequencer one bit at a time. A single write captures every flag at once. After that, the sequencer reads one bit position only. To inspect a flag other than the one at that position, it spends one shift cycle for each place the wanted flag must travel. Choosing a flag is therefore a short sequence of shifts instead of a wide multiplexer.

The register has four flags. Bit 3 is carry, bit 2 is equal, bit 1 is negative and bit 0 is overflow. The readout position is bit 3. Each shift moves the contents one place toward bit 3 and fills bit 0 with zero. The read output comes from a flip-flop. The two operations are controlled by an enable and a load-or-shift select. Both the flag count and the reset value are parameters.

Top module: `flag_shiftreg`

## Requirements
- R1: A synchronous active-high reset clears every stored flag to 0, so `flag_out` reads 0 in the cycle after reset.
- R2: With `cc_en`=1 and `load_nshift`=1, all flags are taken from `flags_in` at the clock edge. `flags_in` is packed as bit 3 carry, bit 2 equal, bit 1 negative, bit 0 overflow.
- R3: Right after a load, `flag_out` shows the carry flag (`flags_in[3]`).
- R4: With `cc_en`=1 and `load_nshift`=0, every stored bit moves one position toward bit 3. After each edge `flag_out` shows the bit that was next in line: equal after one shift, negative after two, overflow after three.
- R5: Each shift puts a 0 into bit 0. After four or more shifts without a load, `flag_out` reads 0.
- R6: With `cc_en`=0, the stored flags and `flag_out` keep their values, whatever `load_nshift` and `flags_in` are.
- R7: When reset and an enabled operation are both active at the same edge, reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_en | input | 1 | Operation enable |
| load_nshift | input | 1 | 1 = parallel load, 0 = shift by one |
| flags_in | input | 4 | Flag vector {carry, equal, negative, overflow} |
| flag_out | output | 1 | Flag at the readout position |

## Verification
A load and a shift can follow each other on back-to-back edges. The bench therefore mixes loads that interrupt a partly shifted register with held cycles placed between shifts. It checks that a new load fully replaces the leftover shifted contents. Reset is asserted together with an enabled load, and the bench expects a zero readout. Every edge adds one expected readout bit to a scoreboard queue, computed from a separate model of the requirements. A monitor then compares that bit with `flag_out` in the middle of the next cycle.

// File: rtl/flag_shiftreg_pkg.sv
package flag_shiftreg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } flag_op_e;
endpackage

// File: rtl/flag_op_decode.sv
module flag_op_decode
  import flag_shiftreg_pkg::*;
(
  input  logic     cc_en,
  input  logic     load_nshift,
  output flag_op_e op
);
  always_comb begin
    if (!cc_en)          op = OP_HOLD;
    else if (load_nshift) op = OP_LOAD;
    else                 op = OP_SHIFT;
  end
endmodule

// File: rtl/flag_store.sv
module flag_store
  import flag_shiftreg_pkg::*;
#(
  parameter int                 N_FLAGS   = 4,
  parameter logic [N_FLAGS-1:0] RESET_VAL = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  flag_op_e           op,
  input  logic [N_FLAGS-1:0] flags_in,
  output logic [N_FLAGS-1:0] store_q
);
  localparam int TOP = N_FLAGS - 1;

  logic [N_FLAGS-1:0] next_val;

  generate
    for (genvar b = 0; b < N_FLAGS; b++) begin : g_bit
      if (b == 0) begin : g_tail
        always_comb begin
          unique case (op)
            OP_LOAD:  next_val[b] = flags_in[b];
            OP_SHIFT: next_val[b] = 1'b0;
            default:  next_val[b] = store_q[b];
          endcase
        end
      end else begin : g_body
        always_comb begin
          unique case (op)
            OP_LOAD:  next_val[b] = flags_in[b];
            OP_SHIFT: next_val[b] = store_q[b-1];
            default:  next_val[b] = store_q[b];
          endcase
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) store_q <= RESET_VAL;
    else     store_q <= next_val;
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> $stable(store_q));
  assert_shift_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> (store_q[0] == 1'b0));
  assert_shift_move_R4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> (store_q[TOP:1] == $past(store_q[TOP-1:0])));
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (store_q == $past(flags_in)));
endmodule

// File: rtl/flag_shiftreg.sv
module flag_shiftreg
  import flag_shiftreg_pkg::*;
#(
  parameter int                 N_FLAGS   = 4,
  parameter logic [N_FLAGS-1:0] RESET_VAL = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cc_en,
  input  logic               load_nshift,
  input  logic [N_FLAGS-1:0] flags_in,
  output logic               flag_out
);
  localparam int READ_POS = N_FLAGS - 1;

  flag_op_e           op;
  logic [N_FLAGS-1:0] store_q;

  flag_op_decode u_dec (
    .cc_en       (cc_en),
    .load_nshift (load_nshift),
    .op          (op)
  );

  flag_store #(.N_FLAGS(N_FLAGS), .RESET_VAL(RESET_VAL)) u_store (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .flags_in (flags_in),
    .store_q  (store_q)
  );

  assign flag_out = store_q[READ_POS];

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (flag_out == RESET_VAL[READ_POS]));
  assert_reset_wins_R7: assert property (@(posedge clk)
    (rst && cc_en) |=> (flag_out == RESET_VAL[READ_POS]));
  assert_load_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (cc_en && load_nshift) |=> (flag_out == $past(flags_in[READ_POS])));
  assert_hold_out_R6: assert property (@(posedge clk) disable iff (rst)
    (!cc_en) |=> $stable(flag_out));
endmodule

// File: tb/test_flag_shiftreg.sv
module test_flag_shiftreg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cc_en = 1'b0;
  logic       load_nshift = 1'b0;
  logic [3:0] flags_in = '0;
  logic       flag_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [3:0] model = '0;
  logic       exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_shiftreg i_flag_shiftreg (
    .clk(clk), .rst(rst), .cc_en(cc_en), .load_nshift(load_nshift),
    .flags_in(flags_in), .flag_out(flag_out)
  );

  // Driver: set inputs, update the model, queue the expected readout
  task automatic step(input logic r, input logic en, input logic ld,
                      input logic [3:0] f, input string tag);
    @(negedge clk);
    rst = r; cc_en = en; load_nshift = ld; flags_in = f;
    if (r)             model = '0;
    else if (en && ld) model = f;
    else if (en)       model = {model[2:0], 1'b0};
    exp_q.push_back(model[3]);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare in the middle of the cycle that follows each edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (flag_out !== e) begin
        n_fail++;
        $display("FAIL %s: flag_out=%b expected=%b", t, flag_out, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*2000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 4'h0, "R1 reset");
    step(1, 0, 0, 4'h0, "R1 reset");
    // R2/R3 load, R4 walk through each flag
    step(0, 1, 1, 4'b1010, "R3 carry after load");
    step(0, 1, 0, 4'h0, "R4 equal after 1 shift");
    step(0, 1, 0, 4'h0, "R4 negative after 2 shifts");
    step(0, 1, 0, 4'h0, "R4 overflow after 3 shifts");
    step(0, 1, 0, 4'h0, "R5 zero after 4 shifts");
    step(0, 1, 0, 4'h0, "R5 zero after 5 shifts");
    // R2 load of a second pattern, shifts with holds in between
    step(0, 1, 1, 4'b0111, "R2 load 0111 carry");
    step(0, 0, 1, 4'b1111, "R6 hold ignores load");
    step(0, 0, 0, 4'b1000, "R6 hold ignores shift");
    step(0, 1, 0, 4'h0, "R4 equal after shift");
    step(0, 0, 0, 4'h0, "R6 hold");
    step(0, 1, 0, 4'h0, "R4 negative");
    step(0, 1, 0, 4'h0, "R4 overflow");
    // a load replaces a partly shifted register
    step(0, 1, 1, 4'b1001, "R2 load 1001");
    step(0, 1, 0, 4'h0, "R4 shift 1");
    step(0, 1, 1, 4'b0110, "R2 reload over shifted");
    step(0, 1, 0, 4'h0, "R4 reload equal");
    step(0, 1, 0, 4'h0, "R4 reload negative");
    step(0, 1, 0, 4'h0, "R4 reload overflow");
    // R7: reset together with an enabled load
    step(0, 1, 1, 4'b1111, "R3 load all ones");
    step(1, 1, 1, 4'b1111, "R7 reset beats load");
    step(0, 0, 0, 4'h0, "R6 hold after reset");
    // every pattern: load then walk all bits
    for (int p = 0; p < 16; p++) begin
      step(0, 1, 1, 4'(p), "R2 sweep load");
      for (int s = 0; s < 4; s++) step(0, 1, 0, 4'h0, "R4 sweep shift");
    end
    step(0, 0, 0, 4'h0, "R5 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule